// File: doc/BRIEF.md
# Byte-Lane Register Slave for a 32-bit AHB-Lite Bus

This block is a single-slave AHB-Lite target. It holds a bank of word-aligned 32-bit registers that spans a 16 KB byte-addressed window. Masters may move a byte, a halfword or a full word per transfer. The transfer width and the low address bits together choose which byte lanes of the data buses take part. For a narrow write, only those lanes are merged into the stored register. For a narrow read, only those lanes carry data and every other lane is zero.

A build-time switch removes sub-word support. With the switch off, the slave refuses any byte or halfword transfer with a two-cycle ERROR response and leaves the register untouched. The slave never inserts wait states on a transfer that it accepts. A stall appears only in the first cycle of an ERROR response.

Back-pressure follows the AHB-Lite rule. An address phase is taken only on a rising edge where the shared `hready` is high. A data phase completes on the first rising edge where `hready` is high. The master must therefore hold its address-phase signals and `hwdata` steady while `hready` is low. The upper address bits are decoded outside the block into `hsel`.

Top module: `ahbsw_slave`

## Requirements
- R1: While reset is held and in the first cycle after it, `hreadyout` is 1, `hresp` is 0 and `hrdata` is 0.
- R2: A byte (`hsize`=0) or halfword (`hsize`=1) write changes only the register bytes on the selected lanes. Lane n is bits [8n+7:8n] and serves byte offset n (little-endian). The remaining bytes of that register keep their values.
- R3: A word write (`hsize`=2) replaces all four bytes. A word read returns the stored word in the data phase, which is the cycle after the address phase is accepted.
- R4: A narrow read drives the stored bytes on the selected lanes of `hrdata` and zero on every other lane. `hrdata` is zero in any cycle that is not a read data phase.
- R5: A halfword with `haddr[0]`=1 or a word with `haddr[1:0]`≠0 is misaligned. It gets an ERROR response, and a misaligned write changes no register.
- R6: An ERROR response takes two cycles. In the first cycle `hreadyout` is 0 and `hresp` is 1. In the second cycle `hreadyout` is 1 and `hresp` is 1.
- R7: With `SUBWORD_EN`=0, every byte and halfword transfer gets an ERROR response and changes no register. Word transfers still work.
- R8: IDLE (`htrans`=0), BUSY (`htrans`=1), or any transfer with `hsel` low gets a zero-wait OKAY response and changes no register.
- R9: A transfer with `hsize` greater than 2 gets an ERROR response.
- R10: Accepted OKAY transfers run back to back with no wait state. A read accepted in the data phase of a write to the same register returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Active-low reset |
| hsel | input | 1 | Slave select from the external address decoder |
| htrans | input | 2 | Transfer type: 0 IDLE, 1 BUSY, 2 NONSEQ, 3 SEQ |
| hwrite | input | 1 | 1 for write, 0 for read |
| hsize | input | 3 | Transfer width: 0 byte, 1 halfword, 2 word |
| haddr | input | ADDR_W (14) | Byte address inside the window |
| hwdata | input | DATA_W (32) | Write data, valid in the data phase |
| hready | input | 1 | Bus-wide ready; a phase completes on a high edge |
| hreadyout | output | 1 | Ready driven by this slave |
| hresp | output | 1 | 1 signals ERROR |
| hrdata | output | DATA_W (32) | Read data on the selected lanes |

## Verification
The response to an address phase accepted on edge N is visible after edge N. OKAY read data and the first ERROR cycle appear in the cycle that follows N. The second ERROR cycle appears one edge later. Write data sampled on the edge that closes a data phase is visible to a read accepted on that same edge.

A behavioural model in the bench follows these latencies for two instances, one with sub-word support and one without. It compares `hreadyout`, `hresp` and every known `hrdata` byte on each falling edge. Directed checks read back the registers after merges, rejects and ignored transfers, and they sample the data phase in the falling-edge half-cycle right after the accepting edge.

// File: rtl/ahbsw_pkg.sv
package ahbsw_pkg;

  typedef enum logic [1:0] {
    HT_IDLE   = 2'd0,
    HT_BUSY   = 2'd1,
    HT_NONSEQ = 2'd2,
    HT_SEQ    = 2'd3
  } htrans_e;

  localparam int BYTE_W = 8;

  function automatic logic is_active(logic sel, logic [1:0] tr);
    return sel && (tr == HT_NONSEQ || tr == HT_SEQ);
  endfunction

endpackage

// File: rtl/ahbsw_lane_dec.sv
module ahbsw_lane_dec #(
  parameter int LANES      = 4,
  parameter bit SUBWORD_EN = 1'b1,
  parameter int OFS_W      = $clog2(LANES)
) (
  input  logic [OFS_W-1:0] ofs,
  input  logic [2:0]       size,
  output logic [LANES-1:0] lane_en,
  output logic             bad
);

  logic too_wide;
  logic narrow;
  logic misal;
  int   first;
  int   nbytes;

  always_comb begin
    too_wide = int'(size) > OFS_W;
    narrow   = int'(size) < OFS_W;
    misal    = 1'b0;
    for (int b = 0; b < OFS_W; b++) begin
      if (b < int'(size) && ofs[b]) misal = 1'b1;
    end
    bad    = too_wide || misal || (narrow && !SUBWORD_EN);
    first  = int'(ofs);
    nbytes = too_wide ? 0 : (1 << size);
    for (int l = 0; l < LANES; l++) begin
      lane_en[l] = !bad && (l >= first) && (l < first + nbytes);
    end
  end

endmodule

// File: rtl/ahbsw_pipe.sv
module ahbsw_pipe #(
  parameter int LANES = 4,
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hready,
  input  logic             a_valid,
  input  logic             a_bad,
  input  logic             a_wr,
  input  logic [IDX_W-1:0] a_idx,
  input  logic [LANES-1:0] a_lanes,
  output logic             d_act,
  output logic             d_wr,
  output logic [IDX_W-1:0] d_idx,
  output logic [LANES-1:0] d_lanes,
  output logic             err_1st,
  output logic             err_2nd
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_act   <= 1'b0;
      d_wr    <= 1'b0;
      d_idx   <= '0;
      d_lanes <= '0;
      err_1st <= 1'b0;
      err_2nd <= 1'b0;
    end else if (err_1st) begin
      err_1st <= 1'b0;
      err_2nd <= 1'b1;
    end else if (hready) begin
      d_act   <= a_valid && !a_bad;
      d_wr    <= a_wr;
      d_idx   <= a_idx;
      d_lanes <= a_lanes;
      err_1st <= a_valid && a_bad;
      err_2nd <= 1'b0;
    end
  end

endmodule

// File: rtl/ahbsw_bank.sv
module ahbsw_bank #(
  parameter int NUM_WORDS = 4096,
  parameter int DATA_W    = 32,
  parameter int LANES     = DATA_W / 8,
  parameter int IDX_W     = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [LANES-1:0]  lanes,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] store [NUM_WORDS];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int l = 0; l < LANES; l++) begin
        if (lanes[l]) store[idx][8*l +: 8] <= wdata[8*l +: 8];
      end
    end
  end

  assign rdata = store[idx];

endmodule

// File: rtl/ahbsw_slave.sv
module ahbsw_slave
  import ahbsw_pkg::*;
#(
  parameter int NUM_WORDS  = 4096,
  parameter int DATA_W     = 32,
  parameter bit SUBWORD_EN = 1'b1,
  parameter int ADDR_W     = $clog2(NUM_WORDS * (DATA_W / 8))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsel,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic [2:0]        hsize,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [DATA_W-1:0] hwdata,
  input  logic              hready,
  output logic              hreadyout,
  output logic              hresp,
  output logic [DATA_W-1:0] hrdata
);

  localparam int LANES = DATA_W / BYTE_W;
  localparam int OFS_W = $clog2(LANES);
  localparam int IDX_W = ADDR_W - OFS_W;

  logic             a_valid;
  logic             a_bad;
  logic [LANES-1:0] a_lanes;
  logic             d_act;
  logic             d_wr;
  logic [IDX_W-1:0] d_idx;
  logic [LANES-1:0] d_lanes;
  logic             err_1st;
  logic             err_2nd;
  logic             bank_we;
  logic [DATA_W-1:0] bank_word;

  assign a_valid = is_active(hsel, htrans);

  ahbsw_lane_dec #(
    .LANES(LANES), .SUBWORD_EN(SUBWORD_EN), .OFS_W(OFS_W)
  ) u_dec (
    .ofs(haddr[OFS_W-1:0]), .size(hsize), .lane_en(a_lanes), .bad(a_bad)
  );

  ahbsw_pipe #(.LANES(LANES), .IDX_W(IDX_W)) u_pipe (
    .clk(clk), .rst_n(rst_n), .hready(hready),
    .a_valid(a_valid), .a_bad(a_bad), .a_wr(hwrite),
    .a_idx(haddr[ADDR_W-1:OFS_W]), .a_lanes(a_lanes),
    .d_act(d_act), .d_wr(d_wr), .d_idx(d_idx), .d_lanes(d_lanes),
    .err_1st(err_1st), .err_2nd(err_2nd)
  );

  assign bank_we = d_act && d_wr && hready;

  ahbsw_bank #(
    .NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W), .LANES(LANES), .IDX_W(IDX_W)
  ) u_bank (
    .clk(clk), .we(bank_we), .idx(d_idx), .lanes(d_lanes),
    .wdata(hwdata), .rdata(bank_word)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_rlane
    assign hrdata[8*l +: 8] = (d_act && !d_wr && d_lanes[l]) ? bank_word[8*l +: 8] : 8'h00;
  end

  assign hreadyout = !err_1st;
  assign hresp     = err_1st || err_2nd;

endmodule

// File: rtl/ahbsw_slave_chk.sv
module ahbsw_slave_chk #(
  parameter int DATA_W     = 32,
  parameter bit SUBWORD_EN = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hsel,
  input logic [1:0]        htrans,
  input logic              hwrite,
  input logic [2:0]        hsize,
  input logic [1:0]        lo_addr,
  input logic              hready,
  input logic              hreadyout,
  input logic              hresp,
  input logic [DATA_W-1:0] hrdata
);

  logic go;
  assign go = hready && hsel && (htrans == 2'd2 || htrans == 2'd3);

  AST_ERR_SECOND_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !hreadyout |=> (hreadyout && hresp)); // R6
  AST_STALL_ONLY_ON_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    !hreadyout |-> hresp); // R6
  AST_IDLE_OKAY: assert property (@(posedge clk) disable iff (!rst_n)
    (hready && !go) |=> (hreadyout && !hresp)); // R8
  AST_IDLE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (hready && !go) |=> (hrdata == '0)); // R4
  AST_HALF_MISALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (go && hsize == 3'd1 && lo_addr[0]) |=> (!hreadyout && hresp)); // R5
  AST_WORD_MISALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (go && hsize == 3'd2 && lo_addr != 2'd0) |=> (!hreadyout && hresp)); // R5
  AST_SIZE_TOO_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (go && hsize > 3'd2) |=> (!hreadyout && hresp)); // R9

  if (!SUBWORD_EN) begin : g_nosub
    AST_NARROW_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (go && hsize < 3'd2) |=> (!hreadyout && hresp)); // R7
  end else begin : g_sub
    AST_BYTE_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !hwrite && hsize == 3'd0 && lo_addr == 2'd2)
        |=> (hrdata[15:0] == 16'h0 && hrdata[DATA_W-1:24] == '0)); // R4
  end

endmodule

bind ahbsw_slave ahbsw_slave_chk #(.DATA_W(DATA_W), .SUBWORD_EN(SUBWORD_EN)) u_chk (
  .clk(clk), .rst_n(rst_n), .hsel(hsel), .htrans(htrans), .hwrite(hwrite),
  .hsize(hsize), .lo_addr(haddr[1:0]), .hready(hready),
  .hreadyout(hreadyout), .hresp(hresp), .hrdata(hrdata)
);

// File: tb/ahbsw_slave_test.sv
module ahbsw_ref #(parameter bit SUB = 1'b1) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hready,
  input  logic        hsel,
  input  logic [1:0]  htrans,
  input  logic        hwrite,
  input  logic [2:0]  hsize,
  input  logic [13:0] haddr,
  input  logic [31:0] hwdata,
  output logic        exp_ready,
  output logic        exp_resp,
  output logic [31:0] exp_rdata,
  output logic [31:0] exp_known,
  output int          exp_ph
);
  // ph: 0 none, 1 read, 2 write, 3 first error cycle, 4 second error cycle
  logic [7:0] mem [int];
  int dsz;
  int daddr;
  bit legal;

  initial begin
    exp_ph = 0; exp_ready = 1; exp_resp = 0; exp_rdata = 0; exp_known = '1;
  end

  always @(posedge clk) begin
    if (!rst_n) exp_ph = 0;
    else if (exp_ph == 3) exp_ph = 4;
    else if (hready) begin
      if (exp_ph == 2)
        for (int b = 0; b < (1 << dsz); b++)
          mem[daddr + b] = hwdata[8*((daddr + b) % 4) +: 8];
      if (hsel && htrans >= 2) begin
        legal = (hsize <= 2) && (int'(haddr) % (1 << hsize) == 0) && (SUB || hsize == 2);
        dsz = int'(hsize);
        daddr = int'(haddr);
        exp_ph = !legal ? 3 : (hwrite ? 2 : 1);
      end else exp_ph = 0;
    end
    exp_ready = (exp_ph != 3);
    exp_resp  = (exp_ph >= 3);
    exp_rdata = 0;
    exp_known = '1;
    if (exp_ph == 1)
      for (int b = 0; b < (1 << dsz); b++) begin
        if (mem.exists(daddr + b)) exp_rdata[8*((daddr + b) % 4) +: 8] = mem[daddr + b];
        else exp_known[8*((daddr + b) % 4) +: 8] = 8'h00;
      end
  end
endmodule

module ahbsw_slave_test;
  logic clk = 0;
  logic rst_n = 0;
  logic hsel = 0;
  logic [1:0] htrans = 0;
  logic hwrite = 0;
  logic [2:0] hsize = 0;
  logic [13:0] haddr = 0;
  logic [31:0] hwdata = 0;
  logic hready;
  logic ro_a, rs_a, ro_w, rs_w;
  logic [31:0] rd_a, rd_w;
  logic ea_ready, ea_resp, ew_ready, ew_resp;
  logic [31:0] ea_rdata, ea_known, ew_rdata, ew_known;
  int ea_ph, ew_ph;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [31:0] pend_wd = 0;

  always #10 clk = ~clk;
  assign hready = ro_a & ro_w;

  ahbsw_slave #(.SUBWORD_EN(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .hsel(hsel), .htrans(htrans), .hwrite(hwrite),
    .hsize(hsize), .haddr(haddr), .hwdata(hwdata), .hready(hready),
    .hreadyout(ro_a), .hresp(rs_a), .hrdata(rd_a));
  ahbsw_slave #(.SUBWORD_EN(1'b0)) uut_w (
    .clk(clk), .rst_n(rst_n), .hsel(hsel), .htrans(htrans), .hwrite(hwrite),
    .hsize(hsize), .haddr(haddr), .hwdata(hwdata), .hready(hready),
    .hreadyout(ro_w), .hresp(rs_w), .hrdata(rd_w));

  ahbsw_ref #(.SUB(1'b1)) ref_a (
    .clk(clk), .rst_n(rst_n), .hready(hready), .hsel(hsel), .htrans(htrans),
    .hwrite(hwrite), .hsize(hsize), .haddr(haddr), .hwdata(hwdata),
    .exp_ready(ea_ready), .exp_resp(ea_resp), .exp_rdata(ea_rdata),
    .exp_known(ea_known), .exp_ph(ea_ph));
  ahbsw_ref #(.SUB(1'b0)) ref_w (
    .clk(clk), .rst_n(rst_n), .hready(hready), .hsel(hsel), .htrans(htrans),
    .hwrite(hwrite), .hsize(hsize), .haddr(haddr), .hwdata(hwdata),
    .exp_ready(ew_ready), .exp_resp(ew_resp), .exp_rdata(ew_rdata),
    .exp_known(ew_known), .exp_ph(ew_ph));

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string ph_tag(int ph);
    if (ph >= 3) return "R6 error response";
    if (ph == 0) return "R8 idle okay";
    return "R10 zero-wait okay";
  endfunction

  // Cycle-by-cycle comparison against the reference models
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(ro_a == ea_ready && rs_a == ea_resp, {ph_tag(ea_ph), " (sub)"},
            {30'd0, ro_a, rs_a}, {30'd0, ea_ready, ea_resp});
      check((rd_a & ea_known) == (ea_rdata & ea_known), "R4 lanes (R2 merge, sub)",
            rd_a & ea_known, ea_rdata & ea_known);
      check(ro_w == ew_ready && rs_w == ew_resp, {ph_tag(ew_ph), " (R7 word-only)"},
            {30'd0, ro_w, rs_w}, {30'd0, ew_ready, ew_resp});
      check((rd_w & ew_known) == (ew_rdata & ew_known), "R4 lanes (R7 word-only)",
            rd_w & ew_known, ew_rdata & ew_known);
    end
  end

  // Present an address phase at a falling edge; return at the falling edge after acceptance
  task automatic drive(bit sel, logic [1:0] tr, bit wr, logic [2:0] sz,
                       logic [13:0] a, logic [31:0] wd);
    bit rdy;
    hsel = sel; htrans = tr; hwrite = wr; hsize = sz; haddr = a; hwdata = pend_wd;
    forever begin
      rdy = hready;
      @(negedge clk);
      if (rdy) break;
    end
    pend_wd = wd;
  endtask

  task automatic idle();
    drive(0, 2'd0, 0, 3'd0, 14'h0, 32'h0);
  endtask

  task automatic wr(logic [2:0] sz, logic [13:0] a, logic [31:0] wd);
    drive(1, 2'd2, 1, sz, a, wd);
  endtask

  task automatic rd(logic [2:0] sz, logic [13:0] a, logic [31:0] exp_a,
                    logic [31:0] exp_w, string tag);
    drive(1, 2'd2, 0, sz, a, 32'h0);
    check(rd_a == exp_a, {tag, " (sub)"}, rd_a, exp_a);
    check(rd_w == exp_w, {tag, " (word-only)"}, rd_w, exp_w);
  endtask

  // After an address phase that must fail: check both error cycles
  task automatic err_seq(bit on_a, bit on_w, string tag);
    check(ro_a == !on_a && rs_a == on_a, {tag, " first cycle (sub)"},
          {30'd0, ro_a, rs_a}, {30'd0, !on_a, on_a});
    check(ro_w == !on_w && rs_w == on_w, {tag, " first cycle (word-only)"},
          {30'd0, ro_w, rs_w}, {30'd0, !on_w, on_w});
    hsel = 0; htrans = 0;
    @(negedge clk);
    check(ro_a && rs_a == on_a, "R6 second cycle (sub)", {30'd0, ro_a, rs_a}, {30'd0, 1'b1, on_a});
    check(ro_w && rs_w == on_w, "R6 second cycle (word-only)", {30'd0, ro_w, rs_w}, {30'd0, 1'b1, on_w});
  endtask

  task automatic summary();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ro_a && !rs_a && rd_a == 0, "R1 reset (sub)", rd_a, 32'h0);
    check(ro_w && !rs_w && rd_w == 0, "R1 reset (word-only)", rd_w, 32'h0);
    rst_n = 1;
    @(negedge clk);
    check(ro_a && !rs_a && rd_a == 0, "R1 after reset", {rd_a[29:0], ro_a, rs_a}, 32'h2);

    // Word writes, back to back (NONSEQ then SEQ)
    wr(3'd2, 14'h000, 32'h11223344);
    drive(1, 2'd3, 1, 3'd2, 14'h004, 32'h55667788);
    drive(1, 2'd3, 1, 3'd2, 14'h008, 32'h00000000);
    drive(1, 2'd3, 1, 3'd2, 14'h00C, 32'hFFFFFFFF);
    drive(1, 2'd3, 1, 3'd2, 14'h3FFC, 32'hCAFEF00D);
    idle();
    rd(3'd2, 14'h004, 32'h55667788, 32'h55667788, "R3 word read");
    rd(3'd2, 14'h3FFC, 32'hCAFEF00D, 32'hCAFEF00D, "R3 top word read");
    idle();

    // Narrow writes: merged in sub instance, rejected in word-only
    wr(3'd0, 14'h009, 32'h0000A500);
    err_seq(0, 1, "R7 byte write reject");
    wr(3'd1, 14'h00E, 32'hBEEF0000);
    err_seq(0, 1, "R7 half write reject");
    wr(3'd0, 14'h000, 32'h000000AB);
    err_seq(0, 1, "R7 byte write reject");
    idle();
    rd(3'd2, 14'h008, 32'h0000A500, 32'h00000000, "R2 byte merge / R7 unchanged");
    rd(3'd2, 14'h00C, 32'hBEEFFFFF, 32'hFFFFFFFF, "R2 half merge / R7 unchanged");
    rd(3'd2, 14'h000, 32'h112233AB, 32'h11223344, "R2 lane0 merge / R7 unchanged");

    // Narrow reads (word-only instance errors and returns zero)
    rd(3'd0, 14'h00D, 32'h0000FF00, 32'h0, "R4 byte read lane1");
    err_seq(0, 1, "R7 byte read reject");
    rd(3'd1, 14'h002, 32'h11220000, 32'h0, "R4 half read upper");
    err_seq(0, 1, "R7 half read reject");
    rd(3'd0, 14'h003, 32'h11000000, 32'h0, "R4 byte read lane3");
    err_seq(0, 1, "R7 byte read reject");

    // Misaligned and oversize transfers
    wr(3'd1, 14'h005, 32'hFFFFFFFF);
    err_seq(1, 1, "R5 misaligned half");
    wr(3'd2, 14'h006, 32'hFFFFFFFF);
    err_seq(1, 1, "R5 misaligned word");
    wr(3'd3, 14'h008, 32'hFFFFFFFF);
    err_seq(1, 1, "R9 oversize");
    idle();
    rd(3'd2, 14'h004, 32'h55667788, 32'h55667788, "R5 no write on error");
    rd(3'd2, 14'h008, 32'h0000A500, 32'h00000000, "R9 no write on error");

    // Ignored transfers
    drive(1, 2'd0, 1, 3'd2, 14'h000, 32'hFFFFFFFF);
    check(ro_a && !rs_a && rd_a == 0, "R8 IDLE okay", rd_a, 32'h0);
    drive(1, 2'd1, 1, 3'd2, 14'h000, 32'hFFFFFFFF);
    check(ro_a && !rs_a, "R8 BUSY okay", {30'd0, ro_a, rs_a}, 32'h2);
    drive(0, 2'd2, 1, 3'd2, 14'h000, 32'hFFFFFFFF);
    check(ro_w && !rs_w, "R8 unselected okay", {30'd0, ro_w, rs_w}, 32'h2);
    idle();
    rd(3'd2, 14'h000, 32'h112233AB, 32'h11223344, "R8 no effect");

    // Write then read of the same register, no gap
    wr(3'd2, 14'h010, 32'h0BADBEEF);
    check(ro_a && ro_w, "R10 no wait on write", {30'd0, ro_a, ro_w}, 32'h3);
    rd(3'd2, 14'h010, 32'h0BADBEEF, 32'h0BADBEEF, "R10 read after write");
    idle();
    idle();
    summary();
  end
endmodule